// File: doc/BRIEF.md
# Quad-Channel Converter Serial Register Front End

This block is the digital side of a four-channel digital-to-analogue converter. A host shifts 24-bit words in over a three-wire serial port. The port has a serial clock, an active-low frame select and a data line. Each word carries a command, a channel mask and a 16-bit code. Every channel holds two registers. The input register takes newly written codes. The DAC register holds the code that drives the converter.

A level-sensitive load pin moves pending input codes into the DAC registers of all channels at the same moment. If the load pin is held low, the DAC registers follow every input write. A falling edge on the reset pin sets every register to a preset value. While the reset pin stays low, the load pin has no effect. The preset is zero scale or midscale, and the reset-select pin chooses between them. The power-on reset uses the same preset rule.

A serial data output repeats the bit stream 24 falling edges late, so several devices can share one chain. All serial and control pins are sampled by a fast system clock. Their edges are found after a two-stage synchroniser, so the system clock must be several times faster than the serial clock.

Top module: `qdac_serial_regs`

## Requirements
- R1: A frame starts when `sync_n` falls. Each falling `sclk` edge while `sync_n` is low shifts in `sdin`, MSB first. When `sync_n` rises after at least 24 such edges, the last 24 bits are decoded and acted on.
- R2: The frame word has the command in bits 23:20, a channel mask in bits 19:16 (bit 16 = A, 17 = B, 18 = C, 19 = D) and data in bits 15:0. Command 4'h1 writes the data into the input register of every selected channel and marks it pending. The DAC register does not change.
- R3: If `sync_n` rises after fewer than 24 falling `sclk` edges, no register changes.
- R4: `sdo` is updated only on rising `sclk` edges. Each update takes the bit that was shifted in 24 falling edges earlier. `sdo` is 0 after power-on reset.
- R5: Command 4'h2 copies the input register into the DAC register for each selected channel and clears the pending mark. Command 4'h3 writes the data into both registers of each selected channel.
- R6: While `ldac_n` is low and `reset_n` is high, every channel whose input register is pending copies it into its DAC register, and the pending mark clears. Channels that are not pending keep their DAC value.
- R7: When `ldac_n` is held low, a command 4'h1 write reaches the DAC register of the selected channels without a further pulse.
- R8: A falling edge of `reset_n` loads both registers of every channel with 16'h0000 when `rstsel` is 0, or 16'h8000 when `rstsel` is 1, and clears the pending marks. While `reset_n` is low, `ldac_n` has no effect.
- R9: When the power-on reset `rst_n` is low at a clock edge, every register is set to the R8 preset chosen by `rstsel`.
- R10: Command codes other than 4'h1, 4'h2 and 4'h3 change nothing. Channels whose mask bit is 0 are not changed by any command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sclk | input | 1 | Serial clock, idle high |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out for chaining |
| ldac_n | input | 1 | Active-low load of pending codes |
| reset_n | input | 1 | Falling-edge preset, blocks loads while low |
| rstsel | input | 1 | Preset select: 0 = zero scale, 1 = midscale |
| dac_a | output | 16 | DAC register, channel A |
| dac_b | output | 16 | DAC register, channel B |
| dac_c | output | 16 | DAC register, channel C |
| dac_d | output | 16 | DAC register, channel D |

## Verification
The properties assume that every pin level lasts long enough for the synchroniser to see it: at least three system clocks. They also assume `sdin` is stable while the falling `sclk` edge is registered, and that `rstsel` does not change close to a reset edge. The stimulus keeps each `sclk` half period at six system clocks and changes `sdin` only while `sclk` is high. It moves `rstsel` only while the block is idle, well ahead of a reset edge.

// File: rtl/qdac_pkg.sv
// Shared constants and types for the quad serial register front end.
// Assumes exactly four channels and a 4/4/16 frame split.
package qdac_pkg;
    localparam int unsigned CH_N    = 4;
    localparam int unsigned CMD_W   = 4;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned FRAME_W = CMD_W + CH_N + DATA_W;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 4'h0,
        CMD_WR_IN  = 4'h1,
        CMD_COPY   = 4'h2,
        CMD_WR_BOTH = 4'h3
    } cmd_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [CH_N-1:0]   sel;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/qdac_pin_sync.sv
// Multi-stage synchroniser for a group of asynchronous pins.
// Gives the synchronised level and single-cycle rise/fall pulses.
// Assumes each pin level lasts longer than STAGES+1 clock cycles.
module qdac_pin_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    // Shift the pins through the synchroniser chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= IDLE;
            prev <= IDLE;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign lvl  = stg[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/qdac_frame_rx.sv
// Serial frame receiver. It shifts on falling serial-clock pulses while the
// frame is open, counts up to FRAME_W and flags a commit when the frame
// closes with a full count. sdo is updated on rising serial-clock pulses
// with the bit that leaves the register.
// Assumes the edge pulses come from a synchroniser and last one cycle.
module qdac_frame_rx #(
    parameter int unsigned FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               open_pulse,
    input  logic               close_pulse,
    input  logic               framing,
    input  logic               sck_fall,
    input  logic               sck_rise,
    input  logic               sdi,
    output logic               sdo,
    output logic               commit,
    output logic [FRAME_W-1:0] word
);
    localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;
    logic               sdo_q;

    // Shift register and saturating bit counter for the open frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (open_pulse) begin
            cnt <= '0;
        end else if (framing && sck_fall) begin
            sr <= {sr[FRAME_W-2:0], sdi};
            if (cnt != FULL) cnt <= cnt + 1'b1;
        end
    end

    // Launch the outgoing bit on each rising serial-clock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        sdo_q <= 1'b0;
        else if (sck_rise) sdo_q <= sr[FRAME_W-1];
    end

    assign sdo    = sdo_q;
    assign commit = close_pulse && (cnt == FULL);
    assign word   = sr;
endmodule

// File: rtl/qdac_cmd_decode.sv
// Turns a committed frame into per-channel write strobes.
// Assumes commit is a single-cycle pulse with a stable word.
module qdac_cmd_decode
    import qdac_pkg::*;
(
    input  logic              commit,
    input  frame_t            word,
    output logic [CH_N-1:0]   wr_in,
    output logic [CH_N-1:0]   copy,
    output logic [CH_N-1:0]   wr_both,
    output logic [DATA_W-1:0] data
);
    logic is_wr, is_copy, is_both;

    // Classify the command of the committed word.
    always_comb begin
        is_wr   = 1'b0;
        is_copy = 1'b0;
        is_both = 1'b0;
        if (commit) begin
            case (word.cmd)
                CMD_WR_IN:   is_wr   = 1'b1;
                CMD_COPY:    is_copy = 1'b1;
                CMD_WR_BOTH: is_both = 1'b1;
                default:     ;
            endcase
        end
    end

    for (genvar g = 0; g < int'(CH_N); g++) begin : g_ch
        assign wr_in[g]   = is_wr   && word.sel[g];
        assign copy[g]    = is_copy && word.sel[g];
        assign wr_both[g] = is_both && word.sel[g];
    end

    assign data = word.data;
endmodule

// File: rtl/qdac_channel.sv
// One channel: input register, DAC register and pending flag.
// Priority: preset, then write both, then input write, then copy command,
// then the load pin.
// Assumes rstsel is quasi-static.
module qdac_channel #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rstsel,
    input  logic              preset,
    input  logic              wr_in,
    input  logic              copy,
    input  logic              wr_both,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] dac,
    output logic              pending
);
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] inp_q, dac_q, pre_val;
    logic              pend_q;

    assign pre_val = rstsel ? MID : '0;

    // Update the double-buffered registers of this channel.
    always_ff @(posedge clk) begin
        if (!rst_n || preset) begin
            inp_q  <= pre_val;
            dac_q  <= pre_val;
            pend_q <= 1'b0;
        end else if (wr_both) begin
            inp_q  <= data;
            dac_q  <= data;
            pend_q <= 1'b0;
        end else if (wr_in) begin
            inp_q  <= data;
            pend_q <= 1'b1;
        end else if (copy) begin
            dac_q  <= inp_q;
            pend_q <= 1'b0;
        end else if (load && pend_q) begin
            dac_q  <= inp_q;
            pend_q <= 1'b0;
        end
    end

    assign dac     = dac_q;
    assign pending = pend_q;
endmodule

// File: rtl/qdac_serial_regs.sv
// Top of the quad serial register front end. It synchronises the pins,
// receives frames, decodes commands and holds four channels.
// Assumes clk is several times faster than sclk.
module qdac_serial_regs
    import qdac_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              sdin,
    output logic              sdo,
    input  logic              ldac_n,
    input  logic              reset_n,
    input  logic              rstsel,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b,
    output logic [DATA_W-1:0] dac_c,
    output logic [DATA_W-1:0] dac_d
);
    localparam int unsigned PIN_N = 5;
    localparam int unsigned P_SCK = 4, P_SYN = 3, P_SDI = 2, P_LD = 1, P_RST = 0;

    logic [PIN_N-1:0] pin_lvl, pin_rise, pin_fall;
    logic             frm_commit, ldac_xfer, hw_reset, rst_hi;
    logic [FRAME_W-1:0] rx_word;
    frame_t           frm_word;
    logic [CH_N-1:0]  wr_in, copy, wr_both, pend;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] dac_q [CH_N];
    logic [CH_N*DATA_W-1:0] dac_bus;
    logic             edge_unused;

    qdac_pin_sync #(
        .W(PIN_N), .STAGES(SYNC_STAGES), .IDLE(5'b11011)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({sclk, sync_n, sdin, ldac_n, reset_n}),
        .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
    );

    assign edge_unused = ^{pin_rise[P_SYN-1:0], pin_fall[P_SDI:P_LD]};
    assign rst_hi    = pin_lvl[P_RST];
    assign hw_reset  = pin_fall[P_RST];
    assign ldac_xfer = ~pin_lvl[P_LD] & rst_hi;

    qdac_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .open_pulse(pin_fall[P_SYN]), .close_pulse(pin_rise[P_SYN]),
        .framing(~pin_lvl[P_SYN]),
        .sck_fall(pin_fall[P_SCK]), .sck_rise(pin_rise[P_SCK]),
        .sdi(pin_lvl[P_SDI]), .sdo(sdo),
        .commit(frm_commit), .word(rx_word)
    );

    assign frm_word = frame_t'(rx_word);

    qdac_cmd_decode u_dec (
        .commit(frm_commit), .word(frm_word),
        .wr_in(wr_in), .copy(copy), .wr_both(wr_both), .data(wr_data)
    );

    for (genvar g = 0; g < int'(CH_N); g++) begin : g_chan
        qdac_channel #(.DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .rstsel(rstsel), .preset(hw_reset),
            .wr_in(wr_in[g]), .copy(copy[g]), .wr_both(wr_both[g]),
            .load(ldac_xfer), .data(wr_data),
            .dac(dac_q[g]), .pending(pend[g])
        );
        assign dac_bus[g*DATA_W +: DATA_W] = dac_q[g];
    end

    assign dac_a = dac_q[0];
    assign dac_b = dac_q[1];
    assign dac_c = dac_q[2];
    assign dac_d = dac_q[3];
endmodule

// File: rtl/qdac_serial_regs_chk.sv
// Property checker for qdac_serial_regs, attached with bind.
// Assumes rstsel is stable around reset edges.
module qdac_serial_regs_chk #(
    parameter int unsigned CH_N   = 4,
    parameter int unsigned DATA_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rstsel,
    input logic                   commit,
    input logic                   ldac_xfer,
    input logic                   hw_reset,
    input logic                   rst_hi,
    input logic                   sck_rise,
    input logic                   sdo,
    input logic [CH_N-1:0]        pend,
    input logic [CH_N*DATA_W-1:0] dac_bus
);
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    // R5/R6: a DAC register changes only after a commit, a load or a preset.
    p_dac_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_bus) |-> $past(commit || ldac_xfer || hw_reset));

    // R8: while the reset pin is low, loads leave the DAC registers alone.
    p_load_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_hi && !commit && !hw_reset) |=> $stable(dac_bus));

    // R8: the preset value follows rstsel.
    p_preset_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset |=> (dac_bus == {CH_N{($past(rstsel) ? MID : {DATA_W{1'b0}})}}));

    // R6: a load with no competing command clears every pending flag.
    p_load_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_xfer && !commit && !hw_reset) |=> (pend == '0));

    // R4: sdo moves only after a rising serial-clock edge.
    p_sdo_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(sck_rise));
endmodule

bind qdac_serial_regs qdac_serial_regs_chk #(
    .CH_N(qdac_pkg::CH_N), .DATA_W(qdac_pkg::DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rstsel(rstsel), .commit(frm_commit),
    .ldac_xfer(ldac_xfer), .hw_reset(hw_reset), .rst_hi(rst_hi),
    .sck_rise(pin_rise[4]), .sdo(sdo), .pend(pend), .dac_bus(dac_bus)
);

// File: tb/tb_qdac_serial_regs.sv
// Self-checking bench for qdac_serial_regs: a vector table, then directed cases.
module tb_qdac_serial_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, ldac_n = 1'b1, reset_n = 1'b1, rstsel = 1'b0;
    logic sdo;
    logic [15:0] dac_a, dac_b, dac_c, dac_d;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    qdac_serial_regs dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
        .sdo(sdo), .ldac_n(ldac_n), .reset_n(reset_n), .rstsel(rstsel),
        .dac_a(dac_a), .dac_b(dac_b), .dac_c(dac_c), .dac_d(dac_d)
    );

    // Entry: {send frame, 24-bit word, pulse load, expected {d,c,b,a}}
    localparam int NV = 13;
    localparam logic [89:0] VEC [NV] = '{
        {1'b1, 24'h111234, 1'b0, 64'h0000_0000_0000_0000}, // R2 write A, DAC untouched
        {1'b0, 24'h000000, 1'b1, 64'h0000_0000_0000_1234}, // R6 load A
        {1'b1, 24'h16ABCD, 1'b0, 64'h0000_0000_0000_1234}, // R2 write B,C
        {1'b0, 24'h000000, 1'b1, 64'h0000_ABCD_ABCD_1234}, // R6 load B,C together
        {1'b1, 24'h385555, 1'b0, 64'h5555_ABCD_ABCD_1234}, // R5 write both D
        {1'b1, 24'h110F0F, 1'b0, 64'h5555_ABCD_ABCD_1234}, // R2 write A
        {1'b1, 24'h210000, 1'b0, 64'h5555_ABCD_ABCD_0F0F}, // R5 copy A
        {1'b0, 24'h000000, 1'b1, 64'h5555_ABCD_ABCD_0F0F}, // R6 nothing pending
        {1'b1, 24'h147777, 1'b0, 64'h5555_ABCD_ABCD_0F0F}, // R2 write C
        {1'b0, 24'h000000, 1'b1, 64'h5555_7777_ABCD_0F0F}, // R6 load C only
        {1'b1, 24'h4FFFFF, 1'b0, 64'h5555_7777_ABCD_0F0F}, // R10 unknown command
        {1'b1, 24'h3F0001, 1'b0, 64'h0001_0001_0001_0001}, // R5 write both, all
        {1'b1, 24'h3A00C3, 1'b0, 64'h00C3_0001_00C3_0001}  // R10 mask B,D only
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] outs();
        return {dac_d, dac_c, dac_b, dac_a};
    endfunction

    // Send n bits MSB first and record sdo just before each falling edge.
    task automatic send(input logic [47:0] bits, input int n, output logic [47:0] seen);
        seen = '0;
        sync_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < n; i++) begin
            sdin = bits[n-1-i];
            wait_clk(6);
            seen[47-i] = sdo;
            sclk = 1'b0;
            wait_clk(6);
            sclk = 1'b1;
        end
        wait_clk(6);
        sync_n = 1'b1;
        sdin = 1'b0;
        wait_clk(10);
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0;
        wait_clk(6);
        ldac_n = 1'b1;
        wait_clk(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] seen;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check("R9 zero-scale power-on", outs(), 64'h0);
        check("R4 sdo after reset", {63'h0, sdo}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][89]) send({24'h0, VEC[i][88:65]}, 24, seen);
            if (VEC[i][64]) pulse_ldac();
            check($sformatf("R%0d vector %0d", (VEC[i][64] ? 6 : 2), i), outs(), VEC[i][63:0]);
        end

        // R3: short frame is discarded
        send({28'h0, 20'h3FFFF}, 20, seen);
        check("R3 short frame", outs(), 64'h00C3_0001_00C3_0001);

        // R1 and R4: 48-bit chain, last 24 bits decoded, first word echoed
        send({24'h311111, 24'h322222}, 48, seen);
        check("R4 sdo echo", {40'h0, seen[23:0]}, {40'h0, 24'h311111});
        check("R1 last word decoded", outs(), 64'h00C3_0001_2222_0001);

        // R7: load held low, write goes straight through
        ldac_n = 1'b0;
        wait_clk(6);
        send({24'h0, 24'h143333}, 24, seen);
        check("R7 held load", outs(), 64'h00C3_3333_2222_0001);
        ldac_n = 1'b1;
        wait_clk(6);

        // R8: reset edge to midscale, loads ignored while low
        send({24'h0, 24'h114444}, 24, seen);
        check("R2 pending write", outs(), 64'h00C3_3333_2222_0001);
        rstsel = 1'b1;
        wait_clk(4);
        reset_n = 1'b0;
        wait_clk(8);
        check("R8 midscale preset", outs(), 64'h8000_8000_8000_8000);
        send({24'h0, 24'h114444}, 24, seen);
        pulse_ldac();
        check("R8 load ignored in reset", outs(), 64'h8000_8000_8000_8000);
        reset_n = 1'b1;
        wait_clk(8);
        check("R8 release keeps value", outs(), 64'h8000_8000_8000_8000);
        pulse_ldac();
        check("R6 load after release", outs(), 64'h8000_8000_8000_4444);

        // R8: zero-scale preset
        rstsel = 1'b0;
        wait_clk(4);
        reset_n = 1'b0;
        wait_clk(8);
        check("R8 zero preset", outs(), 64'h0);
        reset_n = 1'b1;
        wait_clk(8);

        // R9: power-on reset follows rstsel
        send({24'h0, 24'h3F1357}, 24, seen);
        check("R5 write both all", outs(), 64'h1357_1357_1357_1357);
        rstsel = 1'b1;
        wait_clk(2);
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        check("R9 midscale power-on", outs(), 64'h8000_8000_8000_8000);
        check("R4 sdo cleared by power-on", {63'h0, sdo}, 64'h0);
        rstsel = 1'b0;
        wait_clk(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule